// File: doc/BRIEF.md
# Indirect Bank Configuration Register Port

This block gives a host on a device-control-register bus access to the configuration registers of an external bus controller through two bus locations only. One location holds an index. The other is a data window onto whichever internal register that index selects. Software first writes the index, then reads or writes the window. Behind the window are a configuration word and an access-parameter word for each memory bank, a captured error address, two error status words and one global configuration word.

The controller's error detector reports a failing access with a strobe, the bank number, a write flag and the address. The port latches the first such event. Later events are dropped until software clears the pending status. The external bus cycles themselves are generated elsewhere.

Top module: `xbc_cfg_port`

## Requirements
- R1: Bus register number 0x012 is the index register. A write there stores the whole 32-bit data word. A read there returns the last word written, or 0 after reset.
- R2: Read data is registered. `reg_rdata` takes the addressed value on the clock edge that samples `reg_rd` and holds it until the next read. Its reset value is 0.
- R3: Bus register number 0x013 is the data window. Window indices 0x00 to 0x07 select the bank configuration words of banks 0 to 7, which are fully readable and writable.
- R4: Window indices 0x10 to 0x17 select the bank access-parameter words of banks 0 to 7, which are fully readable and writable.
- R5: Window index 0x23 selects the global configuration word. It is fully writable and resets to 0x80400000.
- R6: Window index 0x20 returns the captured error address. Writes through the window leave it unchanged.
- R7: Window indices 0x21 and 0x22 select error status words A and B. A write clears every bit that is 1 in the written data and leaves the other bits unchanged.
- R8: An error strobe is accepted only when status word A is zero. An accepted error sets bit `err_bank` of status A, sets bit `err_bank` of status B when `err_is_wr` is 1, and loads the error address register. If a clear and an accepted error occur in the same cycle, the bit set by the error wins.
- R9: A window read with any other index returns 0, and a window write with such an index changes no register.
- R10: A read of any bus register number other than 0x012 and 0x013 returns 0, and a write there changes no register.
- R11: Reset clears all bank configuration words, all access-parameter words, both status words and the error address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 10 | Bus register number of the access |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| err_valid | input | 1 | Error event strobe from the bus controller |
| err_bank | input | 3 | Bank number of the failing access |
| err_is_wr | input | 1 | 1 if the failing access was a write |
| err_addr | input | 32 | Address of the failing access |

## Verification
The window is tested with a distinct pattern in every bank configuration word and every access-parameter word, which exposes index aliasing between the two groups and between neighbouring banks. Error events are sent in three situations: with no error pending, with an error already pending, and in the same cycle as a clear. These separate the lock-out from the set-over-clear priority. Unmapped window indices just above each group, an index above the 8-bit range, and bus register numbers next to the pair are read and written, and the neighbouring registers are then read back. A reference model checks the read data on every cycle, so any change to the hold behaviour of the output register is detected.

// File: rtl/xbc_cfg_pkg.sv
package xbc_cfg_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_BCFG,
    TGT_BAP,
    TGT_EADDR,
    TGT_ESTATA,
    TGT_ESTATB,
    TGT_GCFG
  } xbc_tgt_e;

  // window index map: group bases and single entries
  localparam int IDX_BCFG_BASE = 'h00;
  localparam int IDX_BAP_BASE  = 'h10;
  localparam int IDX_EADDR     = 'h20;
  localparam int IDX_ESTATA    = 'h21;
  localparam int IDX_ESTATB    = 'h22;
  localparam int IDX_GCFG      = 'h23;

endpackage

// File: rtl/xbc_idx_decode.sv
module xbc_idx_decode
  import xbc_cfg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic [DATA_W-1:0] idx,
  output xbc_tgt_e          tgt,
  output logic [BANK_W-1:0] bank
);

  localparam logic [DATA_W-1:0] BCFG_LO = DATA_W'(IDX_BCFG_BASE);
  localparam logic [DATA_W-1:0] BCFG_HI = DATA_W'(IDX_BCFG_BASE + NUM_BANKS);
  localparam logic [DATA_W-1:0] BAP_LO  = DATA_W'(IDX_BAP_BASE);
  localparam logic [DATA_W-1:0] BAP_HI  = DATA_W'(IDX_BAP_BASE + NUM_BANKS);

  logic [DATA_W-1:0] off_bcfg;
  logic [DATA_W-1:0] off_bap;

  always_comb begin
    off_bcfg = idx - BCFG_LO;
    off_bap  = idx - BAP_LO;
    tgt      = TGT_NONE;
    bank     = '0;
    if (idx >= BCFG_LO && idx < BCFG_HI) begin
      tgt  = TGT_BCFG;
      bank = off_bcfg[BANK_W-1:0];
    end else if (idx >= BAP_LO && idx < BAP_HI) begin
      tgt  = TGT_BAP;
      bank = off_bap[BANK_W-1:0];
    end else if (idx == DATA_W'(IDX_EADDR)) begin
      tgt = TGT_EADDR;
    end else if (idx == DATA_W'(IDX_ESTATA)) begin
      tgt = TGT_ESTATA;
    end else if (idx == DATA_W'(IDX_ESTATB)) begin
      tgt = TGT_ESTATB;
    end else if (idx == DATA_W'(IDX_GCFG)) begin
      tgt = TGT_GCFG;
    end
  end

endmodule

// File: rtl/xbc_bank_file.sv
module xbc_bank_file #(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              ap_we,
  input  logic [BANK_W-1:0] bank,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_rd,
  output logic [DATA_W-1:0] ap_rd
);

  localparam int FLAT_W = DATA_W * NUM_BANKS;

  logic [FLAT_W-1:0] cfg_flat;
  logic [FLAT_W-1:0] ap_flat;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic              hit;
    logic              cfg_en;
    logic              ap_en;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] ap_q;

    always_comb begin
      hit    = (bank == BANK_W'(g));
      cfg_en = cfg_we && hit;
      ap_en  = ap_we && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
        ap_q  <= '0;
      end else begin
        if (cfg_en) cfg_q <= wdata;
        if (ap_en)  ap_q  <= wdata;
      end
    end

    assign cfg_flat[g*DATA_W +: DATA_W] = cfg_q;
    assign ap_flat[g*DATA_W +: DATA_W]  = ap_q;
  end

  assign cfg_rd = cfg_flat[bank*DATA_W +: DATA_W];
  assign ap_rd  = ap_flat[bank*DATA_W +: DATA_W];

endmodule

// File: rtl/xbc_err_capture.sv
module xbc_err_capture #(
  parameter int DATA_W = 32,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [BANK_W-1:0] err_bank,
  input  logic              err_is_wr,
  input  logic [DATA_W-1:0] err_addr,
  input  logic              clra_we,
  input  logic              clrb_we,
  input  logic [DATA_W-1:0] clr_mask,
  output logic [DATA_W-1:0] eaddr_q,
  output logic [DATA_W-1:0] estata_q,
  output logic [DATA_W-1:0] estatb_q
);

  logic              cap;
  logic [DATA_W-1:0] hit;
  logic [DATA_W-1:0] eaddr_d;
  logic [DATA_W-1:0] estata_d;
  logic [DATA_W-1:0] estatb_d;

  always_comb begin
    cap      = err_valid && (estata_q == '0);
    hit      = DATA_W'(1) << err_bank;
    estata_d = estata_q & ~(clra_we ? clr_mask : '0);
    estatb_d = estatb_q & ~(clrb_we ? clr_mask : '0);
    eaddr_d  = eaddr_q;
    if (cap) begin
      estata_d = estata_d | hit;
      if (err_is_wr) estatb_d = estatb_d | hit;
      eaddr_d = err_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eaddr_q  <= '0;
      estata_q <= '0;
      estatb_q <= '0;
    end else begin
      eaddr_q  <= eaddr_d;
      estata_q <= estata_d;
      estatb_q <= estatb_d;
    end
  end

endmodule

// File: rtl/xbc_cfg_port.sv
module xbc_cfg_port
  import xbc_cfg_pkg::*;
#(
  parameter int                 SEL_W       = 10,
  parameter int                 DATA_W      = 32,
  parameter int                 NUM_BANKS   = 8,
  parameter logic [SEL_W-1:0]   IDX_REG_NUM = 10'h012,
  parameter logic [SEL_W-1:0]   DAT_REG_NUM = 10'h013,
  parameter logic [DATA_W-1:0]  GCFG_RST    = 32'h8040_0000,
  localparam int                BANK_W      = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              err_valid,
  input  logic [BANK_W-1:0] err_bank,
  input  logic              err_is_wr,
  input  logic [DATA_W-1:0] err_addr
);

  logic              hit_idx;
  logic              hit_dat;
  logic              win_we;
  logic [DATA_W-1:0] idx_q;
  logic [DATA_W-1:0] gcfg_q;
  logic              gcfg_en;
  xbc_tgt_e          tgt;
  logic [BANK_W-1:0] tbank;
  logic [DATA_W-1:0] cfg_rd;
  logic [DATA_W-1:0] ap_rd;
  logic [DATA_W-1:0] eaddr;
  logic [DATA_W-1:0] estata;
  logic [DATA_W-1:0] estatb;
  logic [DATA_W-1:0] win_val;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    hit_idx = (reg_sel == IDX_REG_NUM);
    hit_dat = (reg_sel == DAT_REG_NUM);
    win_we  = reg_wr && hit_dat;
    gcfg_en = win_we && (tgt == TGT_GCFG);
  end

  xbc_idx_decode #(
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_dec (
    .idx (idx_q),
    .tgt (tgt),
    .bank(tbank)
  );

  xbc_bank_file #(
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_banks (
    .clk   (clk),
    .rst_n (rst_n),
    .cfg_we(win_we && (tgt == TGT_BCFG)),
    .ap_we (win_we && (tgt == TGT_BAP)),
    .bank  (tbank),
    .wdata (reg_wdata),
    .cfg_rd(cfg_rd),
    .ap_rd (ap_rd)
  );

  xbc_err_capture #(
    .DATA_W(DATA_W),
    .BANK_W(BANK_W)
  ) u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_valid(err_valid),
    .err_bank (err_bank),
    .err_is_wr(err_is_wr),
    .err_addr (err_addr),
    .clra_we  (win_we && (tgt == TGT_ESTATA)),
    .clrb_we  (win_we && (tgt == TGT_ESTATB)),
    .clr_mask (reg_wdata),
    .eaddr_q  (eaddr),
    .estata_q (estata),
    .estatb_q (estatb)
  );

  // read path: window mux then bus-level select
  always_comb begin
    unique case (tgt)
      TGT_BCFG:   win_val = cfg_rd;
      TGT_BAP:    win_val = ap_rd;
      TGT_EADDR:  win_val = eaddr;
      TGT_ESTATA: win_val = estata;
      TGT_ESTATB: win_val = estatb;
      TGT_GCFG:   win_val = gcfg_q;
      default:    win_val = '0;
    endcase
    if (hit_idx)      rd_val = idx_q;
    else if (hit_dat) rd_val = win_val;
    else              rd_val = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      gcfg_q  <= GCFG_RST;
      rdata_q <= '0;
    end else begin
      if (reg_wr && hit_idx) idx_q   <= reg_wdata;
      if (gcfg_en)           gcfg_q  <= reg_wdata;
      if (reg_rd)            rdata_q <= rd_val;
    end
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/xbc_cfg_port_chk.sv
module xbc_cfg_port_chk #(
  parameter int               SEL_W       = 10,
  parameter int               DATA_W      = 32,
  parameter logic [SEL_W-1:0] IDX_REG_NUM = 10'h012,
  parameter logic [SEL_W-1:0] DAT_REG_NUM = 10'h013
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  reg_sel,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              err_valid,
  input logic [DATA_W-1:0] err_addr,
  input logic [DATA_W-1:0] idx_q,
  input logic [DATA_W-1:0] eaddr,
  input logic [DATA_W-1:0] estata
);

  p_idx_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == IDX_REG_NUM) |=> (idx_q == $past(reg_wdata)));

  p_idx_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == IDX_REG_NUM) |=> (reg_rdata == $past(idx_q)));

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  p_eaddr_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> $stable(eaddr));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && estata == '0) |=> (eaddr == $past(err_addr) && estata != '0));

  p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (estata != '0) |=> $stable(eaddr));

  p_unmapped_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel != IDX_REG_NUM && reg_sel != DAT_REG_NUM) |=> (reg_rdata == '0));

endmodule

bind xbc_cfg_port xbc_cfg_port_chk #(
  .SEL_W      (SEL_W),
  .DATA_W     (DATA_W),
  .IDX_REG_NUM(IDX_REG_NUM),
  .DAT_REG_NUM(DAT_REG_NUM)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_sel  (reg_sel),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .err_valid(err_valid),
  .err_addr (err_addr),
  .idx_q    (idx_q),
  .eaddr    (eaddr),
  .estata   (estata)
);

// File: tb/tb_xbc_cfg_port.sv
`timescale 1ns/1ps
module tb_xbc_cfg_port;

  localparam logic [9:0] IDX = 10'h012;
  localparam logic [9:0] DAT = 10'h013;

  logic        clk;
  logic        rst_n;
  logic [9:0]  reg_sel;
  logic        reg_rd;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        err_valid;
  logic [2:0]  err_bank;
  logic        err_is_wr;
  logic [31:0] err_addr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  xbc_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_valid(err_valid), .err_bank(err_bank), .err_is_wr(err_is_wr),
    .err_addr(err_addr)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [31:0] m_idx, m_gcfg, m_ea, m_sa, m_sb, m_rdata;
  logic [31:0] m_bcfg [8];
  logic [31:0] m_bap  [8];

  function automatic logic [31:0] m_read(input logic [9:0] s);
    int i;
    if (s == IDX) return m_idx;
    if (s != DAT) return 0;
    i = int'(m_idx);
    if (m_idx < 8) return m_bcfg[i];
    if (m_idx >= 32'h10 && m_idx < 32'h18) return m_bap[i - 16];
    if (m_idx == 32'h20) return m_ea;
    if (m_idx == 32'h21) return m_sa;
    if (m_idx == 32'h22) return m_sb;
    if (m_idx == 32'h23) return m_gcfg;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idx = 0; m_gcfg = 32'h8040_0000; m_ea = 0; m_sa = 0; m_sb = 0; m_rdata = 0;
      for (int i = 0; i < 8; i++) begin m_bcfg[i] = 0; m_bap[i] = 0; end
    end else begin
      logic [31:0] nrd;
      bit pend;
      nrd  = reg_rd ? m_read(reg_sel) : m_rdata;
      pend = (m_sa != 0);
      if (reg_wr && reg_sel == DAT) begin
        if (m_idx < 8) m_bcfg[int'(m_idx)] = reg_wdata;
        else if (m_idx >= 32'h10 && m_idx < 32'h18) m_bap[int'(m_idx) - 16] = reg_wdata;
        else if (m_idx == 32'h21) m_sa = m_sa & ~reg_wdata;
        else if (m_idx == 32'h22) m_sb = m_sb & ~reg_wdata;
        else if (m_idx == 32'h23) m_gcfg = reg_wdata;
      end
      if (reg_wr && reg_sel == IDX) m_idx = reg_wdata;
      if (err_valid && !pend) begin
        m_sa[err_bank] = 1'b1;
        if (err_is_wr) m_sb[err_bank] = 1'b1;
        m_ea = err_addr;
      end
      m_rdata = nrd;
    end
  end

  // R2: per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      compared++;
      if (reg_rdata !== m_rdata) begin
        mismatched++;
        $display("FAIL R2 per-cycle rdata: actual %h expected %h", reg_rdata, m_rdata);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] s, input logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic bus_rd(input logic [9:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic win_rd(input logic [31:0] i, output logic [31:0] d);
    bus_wr(IDX, i);
    bus_rd(DAT, d);
  endtask

  task automatic win_wr(input logic [31:0] i, input logic [31:0] d);
    bus_wr(IDX, i);
    bus_wr(DAT, d);
  endtask

  task automatic raise_err(input logic [2:0] b, input logic w, input logic [31:0] a);
    @(negedge clk); err_valid = 1; err_bank = b; err_is_wr = w; err_addr = a;
    @(negedge clk); err_valid = 0;
  endtask

  initial begin
    #(20000 * 5);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 0; reg_sel = 0; reg_rd = 0; reg_wr = 0; reg_wdata = 0;
    err_valid = 0; err_bank = 0; err_is_wr = 0; err_addr = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset rdata", reg_rdata, 32'h0);
    rst_n = 1;

    // reset state
    bus_rd(IDX, v);           chk("R1 reset index", v, 32'h0);
    win_rd(32'h23, v);        chk("R5 reset gcfg", v, 32'h8040_0000);
    bus_rd(IDX, v);           chk("R1 index readback", v, 32'h23);
    win_rd(32'h03, v);        chk("R11 reset bank cfg", v, 32'h0);
    win_rd(32'h16, v);        chk("R11 reset access param", v, 32'h0);
    win_rd(32'h21, v);        chk("R11 reset status A", v, 32'h0);
    win_rd(32'h20, v);        chk("R11 reset eaddr", v, 32'h0);

    // bank groups with distinct patterns
    for (int b = 0; b < 8; b++) win_wr(32'(b), 32'hC0DE_0000 | 32'(b * 17));
    for (int b = 0; b < 8; b++) win_wr(32'h10 + 32'(b), 32'hA5A5_0000 ^ 32'(b * 257));
    for (int b = 0; b < 8; b++) begin
      win_rd(32'(b), v);         chk("R3 bank cfg", v, 32'hC0DE_0000 | 32'(b * 17));
      win_rd(32'h10 + 32'(b), v); chk("R4 access param", v, 32'hA5A5_0000 ^ 32'(b * 257));
    end

    win_wr(32'h23, 32'h1234_5678);
    win_rd(32'h23, v);        chk("R5 gcfg write", v, 32'h1234_5678);

    win_wr(32'h20, 32'hFFFF_FFFF);
    win_rd(32'h20, v);        chk("R6 eaddr read-only", v, 32'h0);

    // error capture and lock-out
    raise_err(3'd5, 1'b1, 32'hDEAD_0000);
    win_rd(32'h20, v);        chk("R8 captured addr", v, 32'hDEAD_0000);
    win_rd(32'h21, v);        chk("R8 status A bit", v, 32'h20);
    win_rd(32'h22, v);        chk("R8 status B write bit", v, 32'h20);
    raise_err(3'd2, 1'b1, 32'h0000_BEEF);
    win_rd(32'h20, v);        chk("R8 locked addr", v, 32'hDEAD_0000);
    win_rd(32'h21, v);        chk("R8 locked status A", v, 32'h20);

    // write-one-to-clear
    win_wr(32'h21, 32'h0000_0000);
    win_rd(32'h21, v);        chk("R7 zero write keeps", v, 32'h20);
    win_wr(32'h21, 32'h0000_0020);
    win_rd(32'h21, v);        chk("R7 status A cleared", v, 32'h0);
    win_wr(32'h22, 32'hFFFF_FFDF);
    win_rd(32'h22, v);        chk("R7 status B partial", v, 32'h20);
    win_wr(32'h22, 32'h0000_0020);
    win_rd(32'h22, v);        chk("R7 status B cleared", v, 32'h0);

    // read-type error after clear
    raise_err(3'd1, 1'b0, 32'h0000_1111);
    win_rd(32'h21, v);        chk("R8 read error A", v, 32'h2);
    win_rd(32'h22, v);        chk("R8 read error B", v, 32'h0);
    win_rd(32'h20, v);        chk("R8 new addr", v, 32'h0000_1111);

    // clear and capture in one cycle: set wins
    win_wr(32'h21, 32'h2);
    bus_wr(IDX, 32'h21);
    @(negedge clk);
    reg_sel = DAT; reg_wdata = 32'hFFFF_FFFF; reg_wr = 1;
    err_valid = 1; err_bank = 3'd4; err_is_wr = 0; err_addr = 32'h4444_0000;
    @(negedge clk); reg_wr = 0; err_valid = 0;
    bus_rd(DAT, v);           chk("R8 set over clear", v, 32'h10);

    // unmapped window indices
    win_wr(32'h08, 32'hAAAA_AAAA);
    win_rd(32'h08, v);        chk("R9 unmapped 0x08", v, 32'h0);
    win_rd(32'h07, v);        chk("R9 neighbour bank 7", v, 32'hC0DE_0000 | 32'(7 * 17));
    win_wr(32'h18, 32'hAAAA_AAAA);
    win_rd(32'h18, v);        chk("R9 unmapped 0x18", v, 32'h0);
    win_rd(32'h17, v);        chk("R9 neighbour ap 7", v, 32'hA5A5_0000 ^ 32'(7 * 257));
    win_wr(32'h24, 32'hAAAA_AAAA);
    win_rd(32'h24, v);        chk("R9 unmapped 0x24", v, 32'h0);
    win_rd(32'h123, v);       chk("R9 index above range", v, 32'h0);
    win_rd(32'h23, v);        chk("R9 gcfg untouched", v, 32'h1234_5678);

    // unmapped bus register numbers
    bus_wr(IDX, 32'h23);
    bus_wr(10'h014, 32'h0BAD_0BAD);
    bus_wr(10'h011, 32'h0BAD_0BAD);
    bus_rd(10'h014, v);       chk("R10 read 0x014", v, 32'h0);
    bus_rd(10'h000, v);       chk("R10 read 0x000", v, 32'h0);
    bus_rd(IDX, v);           chk("R10 index untouched", v, 32'h23);
    bus_rd(DAT, v);           chk("R10 gcfg untouched", v, 32'h1234_5678);

    // hold between reads
    repeat (4) @(negedge clk);
    chk("R2 rdata held", reg_rdata, 32'h1234_5678);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule